// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Front-End

This block is the device-side command front-end of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the clock-enable line, the active-low select and strobe lines (`cs_n`, `ras_n`, `cas_n`, `we_n`), the special-function line `dsf`, the bank-select line `a10` and the ten-bit multiplexed address `addr`. It decodes the command, checks it against the open or idle state of both banks, latches the row and column addresses and keeps the mode register. A one-cycle strobe reports each command it accepts. The storage array, data path, refresh counters and analog timing checks belong to other blocks.

The clock-enable line drives a three-state machine. In ST_RUN commands are accepted. In ST_SUSPEND the internal clock is stopped and every output holds its value. In ST_PWRDN the block is powered down with both banks idle. Transitions: T_SUSPEND (ST_RUN to ST_SUSPEND) when `cke` is sampled low and a bank would still be open after that edge. T_ENTER_PD (ST_RUN to ST_PWRDN) when `cke` is sampled low and both banks would be idle after that edge. T_RESUME (ST_SUSPEND to ST_RUN) and T_EXIT_PD (ST_PWRDN to ST_RUN) when `cke` is sampled high. In every other case the state holds. The command on the edge that samples `cke` low is still processed. After `cke` is sampled high again, commands are accepted from the next edge.

Top module: `sgdram_cmd_frontend`

## Requirements
- R1: With `cs_n` high the cycle is a deselect: no strobe, and the banks, addresses and mode register keep their values, whatever the other lines carry. With `cs_n` low and `ras_n`,`cas_n`,`we_n` = 111 the cycle is a NOP with the same effect. Pattern 110 is also treated as a NOP.
- R2: An accepted command gives `cmd_valid` high for the one cycle after its edge, with `cmd_code` set as follows (patterns are `ras_n`,`cas_n`,`we_n` with `cs_n` low). Activate is 011, code 1. Read is 101, code 2. Write is 100, code 3. Precharge is 010, code 4. Auto refresh is 001, code 5. Mode register set is 000 with `dsf` low, code 6. `cmd_code` holds its value between strobes and resets to 0.
- R3: Pattern 000 with `dsf` high is not a mode register set. It is ignored: no strobe and no change to the mode register.
- R4: A mode register set is accepted only when both banks are idle, and takes effect in one clock. It sets `burst_len`=A2..A0, `burst_type`=A3, `lat_mode`=A6..A4, `wr_burst`=A9, and `mode_valid`=1. `mode_std` is 1 exactly when A7, A8 and `a10` were all 0. If a bank is open the write is refused and the mode register is unchanged.
- R5: `bank_sel` takes `a10` (0 = bank A, 1 = bank B) on every accepted activate, read, write, precharge and mode register set. An accepted activate to an idle bank opens it (`bank_open[a10]`=1) and loads `row_addr` from A9..A0.
- R6: An accepted read or write must target an open bank. It loads `col_addr` from A7..A0.
- R7: Precharge makes the addressed bank idle; precharging an idle bank is accepted and has no other effect. Auto refresh is accepted only when both banks are idle.
- R8: An activate to an open bank, a read or write to an idle bank, or an auto refresh or mode register set while a bank is open is ignored. It sets `proto_err`, which stays high until reset.
- R9: After an edge that samples `cke` low with a bank open, `frozen` is high from the next cycle. No command is accepted while `frozen` is high, and all outputs other than the strobe hold.
- R10: After an edge that samples `cke` low with both banks idle after that edge, `pwr_down` and `frozen` are high. The edge that samples `cke` high clears both flags, and a command on the following edge is accepted.
- R11: After reset both banks are idle, all flags are 0 (including `mode_valid`), and the latched addresses, mode fields and `cmd_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function qualifier |
| a10 | input | 1 | Bank select / mode bit |
| addr | input | ROW_W | Multiplexed address A9..A0 |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 3 | Code of the last accepted command |
| bank_sel | output | 1 | Last latched bank |
| row_addr | output | ROW_W | Last activated row |
| col_addr | output | COL_W | Last read or write column |
| bank_open | output | 2 | Per-bank open flag |
| burst_len | output | 3 | Mode: burst length code |
| burst_type | output | 1 | Mode: burst type |
| lat_mode | output | 3 | Mode: addressing and latency code |
| wr_burst | output | 1 | Mode: write burst length |
| mode_std | output | 1 | Reserved mode bits were zero |
| mode_valid | output | 1 | Mode register has been written |
| proto_err | output | 1 | Sticky protocol-error flag |
| frozen | output | 1 | Internal clock suspended |
| pwr_down | output | 1 | Power-down state |

## Verification
The assertions assume that every input is 0 or 1 at each sampled edge and that reset is held across at least one edge. They also assume that `bank_sel` names the bank of the command just strobed, so the read and write check may index `bank_open` with it. The bench changes inputs only on falling edges, so every edge sees stable, known values. Its random mix gives precharge extra weight so that both banks are idle often enough to reach mode register sets, refreshes and power-down. It holds `cke` low for runs of several cycles so that both frozen states are entered and left.

// File: rtl/sgdram_pkg.sv
package sgdram_pkg;
    localparam int NUM_BANKS = 2;
    localparam int CODE_W    = 3;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SUSPEND = 2'd1,
        ST_PWRDN   = 2'd2
    } pstate_e;
endpackage

// File: rtl/sgdram_cmd_decode.sv
module sgdram_cmd_decode
    import sgdram_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic dsf,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b110: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = dsf ? CMD_NOP : CMD_MRS;
            endcase
        end
    end
endmodule

// File: rtl/sgdram_bank_track.sv
module sgdram_bank_track
    import sgdram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_ok,
    input  logic                 pre_ok,
    input  logic                 bank,
    output logic [NUM_BANKS-1:0] open_q,
    output logic [NUM_BANKS-1:0] open_d
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            open_d[b] = open_q[b];
            if (act_ok && (int'(bank) == b))
                open_d[b] = 1'b1;
            else if (pre_ok && (int'(bank) == b))
                open_d[b] = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) open_q[b] <= 1'b0;
            else        open_q[b] <= open_d[b];
        end
    end
endmodule

// File: rtl/sgdram_mode_reg.sv
module sgdram_mode_reg #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [ROW_W-1:0] din,
    input  logic             a10,
    output logic [2:0]       burst_len,
    output logic             burst_type,
    output logic [2:0]       lat_mode,
    output logic             wr_burst,
    output logic             mode_std,
    output logic             mode_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_len  <= '0;
            burst_type <= 1'b0;
            lat_mode   <= '0;
            wr_burst   <= 1'b0;
            mode_std   <= 1'b0;
            mode_valid <= 1'b0;
        end else if (wr) begin
            burst_len  <= din[2:0];
            burst_type <= din[3];
            lat_mode   <= din[6:4];
            wr_burst   <= din[9];
            mode_std   <= (din[8:7] == 2'b00) && !a10;
            mode_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/sgdram_cmd_frontend.sv
module sgdram_cmd_frontend
    import sgdram_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 dsf,
    input  logic                 a10,
    input  logic [ROW_W-1:0]     addr,
    output logic                 cmd_valid,
    output logic [CODE_W-1:0]    cmd_code,
    output logic                 bank_sel,
    output logic [ROW_W-1:0]     row_addr,
    output logic [COL_W-1:0]     col_addr,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [2:0]           burst_len,
    output logic                 burst_type,
    output logic [2:0]           lat_mode,
    output logic                 wr_burst,
    output logic                 mode_std,
    output logic                 mode_valid,
    output logic                 proto_err,
    output logic                 frozen,
    output logic                 pwr_down
);
    cmd_e    dec;
    pstate_e state_q, state_d;
    logic    run, all_idle, tgt_open;
    logic    act_ok, rw_ok, pre_ok, ref_ok, mrs_ok, accepted, bad_cmd;
    logic [NUM_BANKS-1:0] open_d;

    sgdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .cmd(dec)
    );

    assign run      = (state_q == ST_RUN);
    assign all_idle = ~|bank_open;
    assign tgt_open = bank_open[a10];

    always_comb begin
        act_ok  = run && (dec == CMD_ACT) && !tgt_open;
        rw_ok   = run && ((dec == CMD_RD) || (dec == CMD_WR)) && tgt_open;
        pre_ok  = run && (dec == CMD_PRE);
        ref_ok  = run && (dec == CMD_REF) && all_idle;
        mrs_ok  = run && (dec == CMD_MRS) && all_idle;
        bad_cmd = run && (((dec == CMD_ACT) && tgt_open) ||
                          (((dec == CMD_RD) || (dec == CMD_WR)) && !tgt_open) ||
                          (((dec == CMD_REF) || (dec == CMD_MRS)) && !all_idle));
        accepted = act_ok || rw_ok || pre_ok || ref_ok || mrs_ok;
    end

    sgdram_bank_track u_banks (
        .clk(clk), .rst_n(rst_n), .act_ok(act_ok), .pre_ok(pre_ok),
        .bank(a10), .open_q(bank_open), .open_d(open_d)
    );

    sgdram_mode_reg #(.ROW_W(ROW_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr(mrs_ok), .din(addr), .a10(a10),
        .burst_len(burst_len), .burst_type(burst_type), .lat_mode(lat_mode),
        .wr_burst(wr_burst), .mode_std(mode_std), .mode_valid(mode_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (!cke) state_d = (~|open_d) ? ST_PWRDN : ST_SUSPEND;
            ST_SUSPEND: if (cke)  state_d = ST_RUN;
            ST_PWRDN:   if (cke)  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    assign frozen   = (state_q != ST_RUN);
    assign pwr_down = (state_q == ST_PWRDN);

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            bank_sel  <= 1'b0;
            row_addr  <= '0;
            col_addr  <= '0;
            proto_err <= 1'b0;
        end else begin
            cmd_valid <= accepted;
            if (accepted) cmd_code <= dec;
            if (act_ok || rw_ok || pre_ok || mrs_ok) bank_sel <= a10;
            if (act_ok) row_addr <= addr;
            if (rw_ok)  col_addr <= addr[COL_W-1:0];
            if (bad_cmd) proto_err <= 1'b1;
        end
    end
endmodule

// File: rtl/sgdram_cmd_frontend_chk.sv
module sgdram_cmd_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       dsf,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       bank_sel,
    input logic [9:0] row_addr,
    input logic [1:0] bank_open,
    input logic       proto_err,
    input logic       frozen,
    input logic       pwr_down
);
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !cmd_valid); // R1

    AST_DSF_BLOCKS_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && dsf) |=> !(cmd_valid && cmd_code == 3'd6)); // R3

    AST_MRS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd6) |-> (bank_open == 2'b00)); // R4

    AST_RW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 3'd2 || cmd_code == 3'd3)) |-> bank_open[bank_sel]); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R8

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> (!cmd_valid && $stable(row_addr) && $stable(bank_open))); // R9

    AST_PDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (bank_open == 2'b00 && frozen)); // R10
endmodule

bind sgdram_cmd_frontend sgdram_cmd_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .bank_sel(bank_sel), .row_addr(row_addr), .bank_open(bank_open),
    .proto_err(proto_err), .frozen(frozen), .pwr_down(pwr_down)
);

// File: tb/sgdram_cmd_frontend_tb.sv
`timescale 1ns/1ps
module sgdram_cmd_frontend_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b1, a10 = 1'b0;
    logic [9:0] addr = '0;
    logic       cmd_valid, bank_sel, burst_type, wr_burst, mode_std, mode_valid;
    logic       proto_err, frozen, pwr_down;
    logic [2:0] cmd_code, burst_len, lat_mode;
    logic [9:0] row_addr;
    logic [7:0] col_addr;
    logic [1:0] bank_open;

    int total = 0, bad = 0;
    bit done = 0;

    // reference state
    int         m_st = 0;
    logic       m_valid = 0, m_bank = 0, m_err = 0;
    logic [2:0] m_code = 0, m_bl = 0, m_lat = 0;
    logic       m_bt = 0, m_wb = 0, m_std = 0, m_mv = 0;
    logic [9:0] m_row = 0;
    logic [7:0] m_col = 0;
    logic [1:0] m_open = 0;

    always #10 clk = ~clk;

    sgdram_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .dsf(dsf), .a10(a10), .addr(addr), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .bank_sel(bank_sel), .row_addr(row_addr), .col_addr(col_addr),
        .bank_open(bank_open), .burst_len(burst_len), .burst_type(burst_type),
        .lat_mode(lat_mode), .wr_burst(wr_burst), .mode_std(mode_std),
        .mode_valid(mode_valid), .proto_err(proto_err), .frozen(frozen), .pwr_down(pwr_down)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [2:0] decode(input logic c, r, s, w, d);
        if (c) return 3'd0;
        case ({r, s, w})
            3'b011: return 3'd1;
            3'b101: return 3'd2;
            3'b100: return 3'd3;
            3'b010: return 3'd4;
            3'b001: return 3'd5;
            3'b000: return d ? 3'd0 : 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic model_edge();
        logic [2:0] k;
        logic run, idle, tgt, ok;
        k = decode(cs_n, ras_n, cas_n, we_n, dsf);
        run = (m_st == 0);
        idle = (m_open == 2'b00);
        tgt = m_open[a10];
        ok = 0;
        if (run) begin
            case (k)
                3'd1: if (!tgt) begin ok = 1; m_open[a10] = 1; m_row = addr; end else m_err = 1;
                3'd2, 3'd3: if (tgt) begin ok = 1; m_col = addr[7:0]; end else m_err = 1;
                3'd4: begin ok = 1; m_open[a10] = 0; end
                3'd5: if (idle) ok = 1; else m_err = 1;
                3'd6: if (idle) begin
                        ok = 1; m_bl = addr[2:0]; m_bt = addr[3]; m_lat = addr[6:4];
                        m_wb = addr[9]; m_std = (addr[8:7] == 0) && !a10; m_mv = 1;
                      end else m_err = 1;
                default: ;
            endcase
        end
        m_valid = ok;
        if (ok) begin
            m_code = k;
            if (k != 3'd5) m_bank = a10;
        end
        if (m_st == 0) begin
            if (!cke) m_st = (m_open == 2'b00) ? 2 : 1;
        end else if (cke) m_st = 0;
    endtask

    task automatic compare_all();
        chk("R2 strobe", {31'd0, cmd_valid}, {31'd0, m_valid});
        chk("R2 code", {29'd0, cmd_code}, {29'd0, m_code});
        chk("R5 bank_sel", {31'd0, bank_sel}, {31'd0, m_bank});
        chk("R5 row", {22'd0, row_addr}, {22'd0, m_row});
        chk("R6 col", {24'd0, col_addr}, {24'd0, m_col});
        chk("R7 bank_open", {30'd0, bank_open}, {30'd0, m_open});
        chk("R4 mode", {21'd0, mode_valid, mode_std, wr_burst, lat_mode, burst_type, burst_len},
                       {21'd0, m_mv, m_std, m_wb, m_lat, m_bt, m_bl});
        chk("R8 proto_err", {31'd0, proto_err}, {31'd0, m_err});
        chk("R9 frozen", {31'd0, frozen}, {31'd0, m_st != 0});
        chk("R10 pwr_down", {31'd0, pwr_down}, {31'd0, m_st == 2});
    endtask

    task automatic step(input logic k, c, r, s, w, d, b, input logic [9:0] a);
        cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; dsf = d; a10 = b; addr = a;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset open", {30'd0, bank_open}, 32'd0);
        chk("R11 reset flags", {27'd0, cmd_valid, mode_valid, proto_err, frozen, pwr_down}, 32'd0);
        chk("R11 reset code", {29'd0, cmd_code}, 32'd0);
        // R1 deselect with all-low lines, then plain NOP
        step(1, 1, 0, 0, 0, 0, 0, 10'h3FF);
        chk("R1 deselect ignored", {31'd0, mode_valid | cmd_valid}, 32'd0);
        step(1, 0, 1, 1, 1, 0, 1, 10'h155);
        chk("R1 nop quiet", {31'd0, cmd_valid}, 32'd0);
        // R3 dsf high
        step(1, 0, 0, 0, 0, 1, 0, 10'h0FF);
        chk("R3 dsf high no mrs", {31'd0, mode_valid}, 32'd0);
        // R4 mode register set
        step(1, 0, 0, 0, 0, 0, 0, 10'b1001011011);
        chk("R4 fields", {23'd0, wr_burst, lat_mode, burst_type, burst_len, mode_std},
            {23'd0, 1'b1, 3'b101, 1'b1, 3'b011, 1'b1});
        // R5 activate, R8 double activate
        step(1, 0, 0, 1, 1, 1, 0, 10'h2A5);
        chk("R5 row latched", {22'd0, row_addr}, 32'h2A5);
        step(1, 0, 0, 1, 1, 1, 0, 10'h011);
        chk("R8 double act flagged", {31'd0, proto_err}, 32'd1);
        // R4 refused with open bank
        step(1, 0, 0, 0, 0, 0, 0, 10'h000);
        chk("R4 refused", {29'd0, burst_len}, 32'd3);
        // R6 write to open bank A
        step(1, 0, 1, 0, 0, 1, 0, 10'h3C7);
        chk("R6 col latched", {24'd0, col_addr}, 32'hC7);
        // R9 suspend with bank open, activate ignored
        step(0, 0, 1, 1, 1, 1, 0, 10'h000);
        step(0, 0, 0, 1, 1, 1, 1, 10'h123);
        chk("R9 act ignored while frozen", {30'd0, bank_open}, 32'd1);
        step(1, 0, 1, 1, 1, 1, 0, 10'h000);
        // R7 precharge, R10 power down and exit
        step(1, 0, 0, 1, 0, 1, 0, 10'h000);
        chk("R7 precharged", {30'd0, bank_open}, 32'd0);
        step(0, 0, 1, 1, 1, 1, 0, 10'h000);
        chk("R10 in power down", {31'd0, pwr_down}, 32'd1);
        step(1, 0, 1, 1, 1, 1, 0, 10'h000);
        step(1, 0, 0, 1, 1, 1, 1, 10'h0AB);
        chk("R10 command after exit", {30'd0, bank_open}, 32'd2);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] p;
            logic kk;
            kk = cke;
            if ($urandom % 10 == 0) kk = ~cke;
            p = 3'($urandom);
            if ($urandom % 4 == 0) p = 3'b010;
            step(kk, ($urandom % 8 == 0), p[2], p[1], p[0], 1'($urandom),
                 1'($urandom), 10'($urandom));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule